// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the hazard controller of a five-stage in-order pipeline with fetch, decode, execute, memory and write-back stages. It watches the opcodes in decode, execute and memory, the load destination register in execute, the two decode source registers and the branch condition computed in execute. From these it raises three events: a return in flight, a load/use data hazard and a mispredicted conditional jump. It turns them into one hold (stall) and one flush (bubble) request per pipeline register. The requests are combinational, so they take effect on the next rising clock edge.

To show the requests acting on real state, the block also contains a chain of five token registers, one per stage. A token enters at fetch and moves forward each cycle. A flush loads the empty token, and a hold keeps the current token. The opcode codes are parameters. The defaults are jump 7, load 5, return 9 and pop 11. Register ID 15 means "no register".

Top module: `pipe_hazard_unit`

## Requirements
- R1: A return opcode (9) in decode, execute or memory, with no other event, holds fetch (stall bit 0) and flushes decode (bubble bit 1), with every other bit low. Bit i of each vector belongs to stage i: fetch 0, decode 1, execute 2, memory 3, write-back 4.
- R2: Load/use applies when the execute opcode is load (5) or pop (11) and the execute load destination equals decode source A or source B. Alone, it holds fetch and decode and flushes execute: stall 5'b00011, bubble 5'b00100.
- R3: A destination equal to register ID 15 never raises a load/use hazard, even when a source is also 15.
- R4: When the execute opcode is jump (7) and the condition input is 0, decode and execute are flushed (bubble 5'b00110) and nothing is held. A jump with condition 1, or condition 0 under any other opcode, causes no action.
- R5: When load/use and a return coincide, load/use wins: stall 5'b00011, bubble 5'b00100, and decode is not flushed.
- R6: When a misprediction and a return coincide, fetch is held and decode and execute are flushed: stall 5'b00001, bubble 5'b00110.
- R7: No stage ever has hold and flush together. Memory and write-back are always in normal mode.
- R8: Each token register loads its input in normal mode, keeps its value under hold, and loads the empty token 0 under flush, on the rising clock edge.
- R9: An active-low reset, asynchronous, clears every token register to 0. Tokens are read out on pipe_tag_o with stage i at bits [8i+7:8i].
- R10: With no event present, all hold and flush outputs are low. A non-matching load, a matching non-load opcode, or any other opcode is not an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_op_i | input | 4 | Opcode in decode |
| exe_op_i | input | 4 | Opcode in execute |
| mem_op_i | input | 4 | Opcode in memory |
| exe_ldst_i | input | 4 | Load destination register in execute |
| dec_srca_i | input | 4 | Decode source register A |
| dec_srcb_i | input | 4 | Decode source register B |
| exe_cond_i | input | 1 | Branch condition computed in execute |
| fetch_tag_i | input | 8 | Token entering the fetch register |
| stall_o | output | 5 | Per-stage hold request |
| bubble_o | output | 5 | Per-stage flush request |
| pipe_tag_o | output | 40 | Token held in each stage register |

## Verification
Several properties are checked on every cycle. Hold and flush never overlap, and memory and write-back stay normal. Each event, alone or combined, gets its table row, and a 15 destination never raises load/use. Each token register also obeys its load, hold and flush modes. The bench scenarios are the only way to show whole token flows. These are a token frozen in fetch and decode while a gap opens behind it, two slots emptied after a wrong guess, and a return freezing fetch while decode drains. The scenarios also confirm that inputs which are not events leave the pipeline untouched.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned NSTAGE = 5;
  localparam int unsigned STG_F = 0;
  localparam int unsigned STG_D = 1;
  localparam int unsigned STG_E = 2;
  localparam int unsigned STG_M = 3;
  localparam int unsigned STG_W = 4;

  typedef struct packed {
    logic ret_busy;
    logic load_use;
    logic mispredict;
  } hz_events_t;
endpackage

// File: rtl/hz_detect.sv
module hz_detect #(
  parameter int unsigned OPC_W = 4,
  parameter int unsigned REG_W = 4,
  parameter logic [OPC_W-1:0] OP_RET  = 4'd9,
  parameter logic [OPC_W-1:0] OP_LOAD = 4'd5,
  parameter logic [OPC_W-1:0] OP_POP  = 4'd11,
  parameter logic [OPC_W-1:0] OP_JUMP = 4'd7,
  parameter logic [REG_W-1:0] REG_NONE = '1
) (
  input  logic [OPC_W-1:0] dec_op,
  input  logic [OPC_W-1:0] exe_op,
  input  logic [OPC_W-1:0] mem_op,
  input  logic [REG_W-1:0] exe_ldst,
  input  logic [REG_W-1:0] srca,
  input  logic [REG_W-1:0] srcb,
  input  logic             exe_cond,
  output hz_pkg::hz_events_t ev
);
  function automatic logic reg_hit(input logic [REG_W-1:0] dst,
                                   input logic [REG_W-1:0] src);
    return (dst != REG_NONE) && (dst == src);
  endfunction

  function automatic logic is_loader(input logic [OPC_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_POP);
  endfunction

  logic src_match;
  assign src_match = reg_hit(exe_ldst, srca) || reg_hit(exe_ldst, srcb);

  always_comb begin
    ev.ret_busy   = (dec_op == OP_RET) || (exe_op == OP_RET) || (mem_op == OP_RET);
    ev.load_use   = is_loader(exe_op) && src_match;
    ev.mispredict = (exe_op == OP_JUMP) && !exe_cond;
  end
endmodule

// File: rtl/hz_action.sv
module hz_action (
  input  hz_pkg::hz_events_t ev,
  output logic [hz_pkg::NSTAGE-1:0] stall,
  output logic [hz_pkg::NSTAGE-1:0] bubble
);
  import hz_pkg::*;

  always_comb begin
    stall  = '0;
    bubble = '0;
    if (ev.load_use) begin
      stall[STG_F]  = 1'b1;
      stall[STG_D]  = 1'b1;
      bubble[STG_E] = 1'b1;
    end else if (ev.mispredict) begin
      bubble[STG_D] = 1'b1;
      bubble[STG_E] = 1'b1;
      stall[STG_F]  = ev.ret_busy;
    end else if (ev.ret_busy) begin
      stall[STG_F]  = 1'b1;
      bubble[STG_D] = 1'b1;
    end
  end
endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] NOP_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stall,
  input  logic         bubble,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= NOP_VAL;
    else if (bubble)  q <= NOP_VAL;
    else if (!stall)  q <= d;
  end

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> q == NOP_VAL);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !bubble) |=> q == $past(q));
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !bubble) |=> q == $past(d));
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit #(
  parameter int unsigned OPC_W = 4,
  parameter int unsigned REG_W = 4,
  parameter int unsigned TAG_W = 8,
  parameter logic [OPC_W-1:0] OP_RET  = 4'd9,
  parameter logic [OPC_W-1:0] OP_LOAD = 4'd5,
  parameter logic [OPC_W-1:0] OP_POP  = 4'd11,
  parameter logic [OPC_W-1:0] OP_JUMP = 4'd7,
  parameter logic [REG_W-1:0] REG_NONE = '1,
  parameter logic [TAG_W-1:0] NOP_TAG = '0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [OPC_W-1:0]                 dec_op_i,
  input  logic [OPC_W-1:0]                 exe_op_i,
  input  logic [OPC_W-1:0]                 mem_op_i,
  input  logic [REG_W-1:0]                 exe_ldst_i,
  input  logic [REG_W-1:0]                 dec_srca_i,
  input  logic [REG_W-1:0]                 dec_srcb_i,
  input  logic                             exe_cond_i,
  input  logic [TAG_W-1:0]                 fetch_tag_i,
  output logic [hz_pkg::NSTAGE-1:0]        stall_o,
  output logic [hz_pkg::NSTAGE-1:0]        bubble_o,
  output logic [hz_pkg::NSTAGE*TAG_W-1:0]  pipe_tag_o
);
  import hz_pkg::*;

  hz_events_t ev;

  hz_detect #(
    .OPC_W(OPC_W), .REG_W(REG_W), .OP_RET(OP_RET), .OP_LOAD(OP_LOAD),
    .OP_POP(OP_POP), .OP_JUMP(OP_JUMP), .REG_NONE(REG_NONE)
  ) u_detect (
    .dec_op(dec_op_i), .exe_op(exe_op_i), .mem_op(mem_op_i),
    .exe_ldst(exe_ldst_i), .srca(dec_srca_i), .srcb(dec_srcb_i),
    .exe_cond(exe_cond_i), .ev(ev)
  );

  hz_action u_action (
    .ev(ev), .stall(stall_o), .bubble(bubble_o)
  );

  logic [TAG_W-1:0] tag_in [NSTAGE];
  logic [TAG_W-1:0] tag_q  [NSTAGE];

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign tag_in[s] = fetch_tag_i;
    end else begin : g_link
      assign tag_in[s] = tag_q[s-1];
    end
    stage_reg #(.W(TAG_W), .NOP_VAL(NOP_TAG)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .stall(stall_o[s]), .bubble(bubble_o[s]),
      .d(tag_in[s]), .q(tag_q[s])
    );
    assign pipe_tag_o[s*TAG_W +: TAG_W] = tag_q[s];
  end

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o & bubble_o) == '0);
  p_tail_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_o[STG_M] && !stall_o[STG_W] && !bubble_o[STG_M] && !bubble_o[STG_W]);
  p_ret_alone_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.ret_busy && !ev.load_use && !ev.mispredict) |->
      (stall_o == 5'b00001 && bubble_o == 5'b00010));
  p_loaduse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev.load_use |-> (stall_o[STG_F] && stall_o[STG_D] && bubble_o[STG_E]));
  p_loaduse_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.load_use && ev.ret_busy) |-> !bubble_o[STG_D]);
  p_mispredict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev.mispredict |-> (bubble_o[STG_D] && bubble_o[STG_E] && !stall_o[STG_D]));
  p_mis_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.mispredict && ev.ret_busy) |-> stall_o[STG_F]);
  p_none_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_ldst_i == REG_NONE) |-> !ev.load_use);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == '0) |-> (stall_o == '0 && bubble_o == '0));
endmodule

// File: tb/pipe_hazard_unit_tb.sv
module pipe_hazard_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] dop = 4'd1, eop = 4'd1, mop = 4'd1;
  logic [3:0] edst = 4'hF, sa = 4'hF, sb = 4'hF;
  logic cond = 1'b1;
  logic [7:0] ftag = 8'h00;
  logic [4:0] stall, bubble;
  logic [39:0] tags;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pipe_hazard_unit dut_i (
    .clk(clk), .rst_n(rst_n), .dec_op_i(dop), .exe_op_i(eop), .mem_op_i(mop),
    .exe_ldst_i(edst), .dec_srca_i(sa), .dec_srcb_i(sb), .exe_cond_i(cond),
    .fetch_tag_i(ftag), .stall_o(stall), .bubble_o(bubble), .pipe_tag_o(tags)
  );

  // {dec_op, exe_op, mem_op, exe_ldst, srca, srcb, cond, stall, bubble}
  localparam int NV = 18;
  localparam logic [34:0] VECS [NV] = '{
    {4'd1, 4'd1, 4'd1, 4'hF, 4'hF, 4'hF, 1'b1, 5'b00000, 5'b00000}, // R10 idle
    {4'd9, 4'd1, 4'd1, 4'hF, 4'hF, 4'hF, 1'b1, 5'b00001, 5'b00010}, // R1 ret D
    {4'd1, 4'd9, 4'd1, 4'hF, 4'hF, 4'hF, 1'b1, 5'b00001, 5'b00010}, // R1 ret E
    {4'd1, 4'd1, 4'd9, 4'hF, 4'hF, 4'hF, 1'b1, 5'b00001, 5'b00010}, // R1 ret M
    {4'd1, 4'd5, 4'd1, 4'h3, 4'h3, 4'hF, 1'b1, 5'b00011, 5'b00100}, // R2 srcA
    {4'd1, 4'd5, 4'd1, 4'h2, 4'h1, 4'h2, 1'b1, 5'b00011, 5'b00100}, // R2 srcB
    {4'd1, 4'd11,4'd1, 4'h4, 4'hF, 4'h4, 1'b1, 5'b00011, 5'b00100}, // R2 pop
    {4'd1, 4'd5, 4'd1, 4'h3, 4'h1, 4'h2, 1'b1, 5'b00000, 5'b00000}, // R10 no match
    {4'd1, 4'd5, 4'd1, 4'hF, 4'hF, 4'hF, 1'b1, 5'b00000, 5'b00000}, // R3
    {4'd1, 4'd11,4'd1, 4'hF, 4'hF, 4'h0, 1'b1, 5'b00000, 5'b00000}, // R3
    {4'd1, 4'd3, 4'd1, 4'h3, 4'h3, 4'h3, 1'b1, 5'b00000, 5'b00000}, // R10 non-load
    {4'd1, 4'd7, 4'd1, 4'hF, 4'hF, 4'hF, 1'b0, 5'b00000, 5'b00110}, // R4 mispredict
    {4'd1, 4'd7, 4'd1, 4'hF, 4'hF, 4'hF, 1'b1, 5'b00000, 5'b00000}, // R4 taken
    {4'd1, 4'd1, 4'd1, 4'hF, 4'hF, 4'hF, 1'b0, 5'b00000, 5'b00000}, // R4 non-jump
    {4'd9, 4'd5, 4'd1, 4'h6, 4'h6, 4'hF, 1'b1, 5'b00011, 5'b00100}, // R5 ret D
    {4'd1, 4'd11,4'd9, 4'h1, 4'h0, 4'h1, 1'b1, 5'b00011, 5'b00100}, // R5 ret M
    {4'd9, 4'd7, 4'd1, 4'hF, 4'hF, 4'hF, 1'b0, 5'b00001, 5'b00110}, // R6 ret D
    {4'd1, 4'd7, 4'd9, 4'hF, 4'hF, 4'hF, 1'b0, 5'b00001, 5'b00110}  // R6 ret M
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [3:0] d, e, m, ld, a, b, input logic c);
    dop = d; eop = e; mop = m; edst = ld; sa = a; sb = b; cond = c;
  endtask

  task automatic step(input logic [3:0] d, e, m, ld, a, b, input logic c,
                      input logic [7:0] t, input logic [39:0] exp, input string req);
    @(negedge clk);
    set_ctl(d, e, m, ld, a, b, c);
    ftag = t;
    @(posedge clk);
    #1;
    chk(req, {24'd0, tags}, {24'd0, exp});
  endtask

  initial begin
    #(4 * 2000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset", {24'd0, tags}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {dop, eop, mop, edst, sa, sb, cond} = VECS[i][34:10];
      #1;
      chk($sformatf("R7 vec%0d table", i), {54'd0, stall, bubble},
          {54'd0, VECS[i][9:0]});
      chk($sformatf("R7 vec%0d excl", i), {59'd0, stall & bubble}, 64'd0);
    end

    @(negedge clk);
    set_ctl(4'd1, 4'd1, 4'd1, 4'hF, 4'hF, 4'hF, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset", {24'd0, tags}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // tags packed as {W, M, E, D, F}
    step(4'd1, 4'd1, 4'd1, 4'hF, 4'hF, 4'hF, 1'b1, 8'h11, 40'h00_00_00_00_11, "R8 load");
    step(4'd1, 4'd1, 4'd1, 4'hF, 4'hF, 4'hF, 1'b1, 8'h22, 40'h00_00_00_11_22, "R8 load");
    step(4'd1, 4'd1, 4'd1, 4'hF, 4'hF, 4'hF, 1'b1, 8'h33, 40'h00_00_11_22_33, "R8 load");
    step(4'd1, 4'd1, 4'd1, 4'hF, 4'hF, 4'hF, 1'b1, 8'h44, 40'h00_11_22_33_44, "R8 load");
    step(4'd1, 4'd5, 4'd1, 4'h2, 4'h2, 4'hF, 1'b1, 8'h55, 40'h11_22_00_33_44, "R2 load/use flow");
    step(4'd1, 4'd1, 4'd1, 4'hF, 4'hF, 4'hF, 1'b1, 8'h66, 40'h22_00_33_44_66, "R8 resume");
    step(4'd1, 4'd7, 4'd1, 4'hF, 4'hF, 4'hF, 1'b0, 8'h77, 40'h00_33_00_00_77, "R4 mispredict flow");
    step(4'd1, 4'd1, 4'd1, 4'hF, 4'hF, 4'hF, 1'b1, 8'h88, 40'h33_00_00_77_88, "R8 resume");
    step(4'd9, 4'd1, 4'd1, 4'hF, 4'hF, 4'hF, 1'b1, 8'h99, 40'h00_00_77_00_88, "R1 return flow");
    step(4'd1, 4'd3, 4'd1, 4'h3, 4'h3, 4'h3, 1'b1, 8'hAA, 40'h00_77_00_88_AA, "R10 no effect");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule